// File: doc/BRIEF.md
# Configurable Drive-Mode I/O Port

This block is one eight-pin general-purpose I/O port that software controls through a small synchronous register bus. Each pin has a three-bit drive-mode code. The code is spread across three mode registers, one bit of the code per register, always at the same bit position as the pin. A lane for each pin turns its code and its output value into the enables an abstract pad model needs: strong drive high, strong drive low, resistive pull-up, resistive pull-down and input-buffer enable. A further flag marks the slope-limited strong mode.

An output latch holds the value each pin drives. A read of the data address returns what the pins really carry, after a two-flop synchronizer, and never the latch contents. For this reason a read-modify-write on a port that mixes pulled inputs with outputs can lock a pulled input at one level. A per-pin global-select bit re-routes the pin. In the high-impedance modes the pin feeds an internal global input bus. In every other mode the pad takes its output value from an internal global output bus.

Top module: `pinmode_port`

## Requirements
- R1: After synchronous reset, every pin is in mode 110. The mode registers at addresses 1, 2 and 3 read 0x00, 0xFF and 0xFF, the select register reads 0x00, and no pad drive, pull or input enable is active.
- R2: Bit n of the registers at address 1 (code bit 0), address 2 (code bit 1) and address 3 (code bit 2) forms the mode of pin n alone, so different pins hold different modes at the same time.
- R3: Code 001 drives the pad strongly to the output value in both directions. Code 101 does the same and also raises the slow flag. No other code raises the slow flag, and no pin ever drives high and low together.
- R4: Code 100 drives high for a 1 and floats for a 0. Code 111 drives low for a 0 and floats for a 1.
- R5: Code 000 drives high for a 1 and enables the pull-down for a 0. Code 011 enables the pull-up for a 1 and drives low for a 0.
- R6: Codes 010 and 110 never drive or pull the pad, whatever the output latch holds. Code 110 also turns the input buffer off, so that pin reads 0 at the data address.
- R7: A write to address 0 loads the output latch. A read of address 0 returns the synchronized pin levels, so a read-modify-write copies a pulled input's level into its latch bit.
- R8: A pin change first shows in a read of address 0 whose result comes out on the third rising edge after the change. Read data appears one cycle after the address is presented.
- R9: With select bit n set and a non-high-impedance mode, pin n takes its output value from global output bus bit n instead of the latch.
- R10: With select bit n set and code 010, global input bus bit n carries the synchronized pin level. That bit is 0 when the select bit is clear or the code is 110.
- R11: Registers at addresses 1 to 4 read back what was written. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address (0 data, 1-3 mode bits, 4 select) |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the address |
| pad_in | input | 8 | Levels seen on the pads |
| pad_drv_hi | output | 8 | Strong drive high enable per pin |
| pad_drv_lo | output | 8 | Strong drive low enable per pin |
| pad_pull_up | output | 8 | Resistive pull-up enable per pin |
| pad_pull_dn | output | 8 | Resistive pull-down enable per pin |
| pad_in_en | output | 8 | Digital input buffer enable per pin |
| pad_slow | output | 8 | Slope-limited strong mode flag per pin |
| gbus_out | input | 8 | Global output bus, one bit per pin |
| gbus_in | output | 8 | Global input bus, one bit per pin |

## Verification
The pad enables are combinational from the registers. A wrong mode-register bit or a wrong decode therefore shows on the pad outputs in the same cycle the write takes effect, and the table of all sixteen code and value pairs catches it there. A wrong synchronizer depth or a wrong read pipeline shows as a read result one edge early or late, so the bench samples a held read on each of three successive edges. A wrong reset value or a mis-decoded address shows at once as a bad readback of the mode, select or unmapped addresses.

// File: rtl/pinmode_pkg.sv
// Package: shared constants and types for the drive-mode I/O port.
// Assumes a register bus of at most eight addresses; unmapped ones read 0.
package pinmode_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    // Register addresses.
    localparam int A_DATA  = 0;
    localparam int A_MODE0 = 1;
    localparam int A_MODE1 = 2;
    localparam int A_MODE2 = 3;
    localparam int A_GSEL  = 4;

    // Three-bit drive-mode codes, {bit2, bit1, bit0}.
    typedef enum logic [2:0] {
        MODE_PULL_DN = 3'b000,
        MODE_STRONG  = 3'b001,
        MODE_HIZ_DIG = 3'b010,
        MODE_PULL_UP = 3'b011,
        MODE_OD_HI   = 3'b100,
        MODE_SLOW    = 3'b101,
        MODE_HIZ_ANA = 3'b110,
        MODE_OD_LO   = 3'b111
    } drv_mode_e;

    localparam logic [2:0] RESET_MODE = MODE_HIZ_ANA;

    // Per-pin pad controls.
    typedef struct packed {
        logic slow;
        logic in_en;
        logic pull_dn;
        logic pull_up;
        logic drv_lo;
        logic drv_hi;
    } pad_ctl_t;

endpackage

// File: rtl/pinmode_sync.sv
// Module: multi-stage synchronizer for the pad input levels.
// Assumes pad inputs are asynchronous to clk; STAGES is at least 2.
module pinmode_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    // Shift pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/pinmode_regs.sv
// Module: register file and read path of the port.
// Holds the output latch, three mode-bit registers and the select register.
// Assumes pin_level is already synchronized and gated by the input buffer.
module pinmode_regs
    import pinmode_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  pin_level,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  mode0_q,
    output logic [W-1:0]  mode1_q,
    output logic [W-1:0]  mode2_q,
    output logic [W-1:0]  gsel_q
);

    localparam logic [W-1:0] MODE0_RST = {W{RESET_MODE[0]}};
    localparam logic [W-1:0] MODE1_RST = {W{RESET_MODE[1]}};
    localparam logic [W-1:0] MODE2_RST = {W{RESET_MODE[2]}};

    logic [W-1:0] rd_mux;

    // Register writes; unmapped addresses are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            mode0_q <= MODE0_RST;
            mode1_q <= MODE1_RST;
            mode2_q <= MODE2_RST;
            gsel_q  <= '0;
        end else if (we) begin
            if (addr == AW'(A_DATA))  latch_q <= wdata;
            if (addr == AW'(A_MODE0)) mode0_q <= wdata;
            if (addr == AW'(A_MODE1)) mode1_q <= wdata;
            if (addr == AW'(A_MODE2)) mode2_q <= wdata;
            if (addr == AW'(A_GSEL))  gsel_q  <= wdata;
        end
    end

    // Select read source; the data address returns pin levels.
    always_comb begin
        rd_mux = '0;
        if (addr == AW'(A_DATA))  rd_mux = pin_level;
        if (addr == AW'(A_MODE0)) rd_mux = mode0_q;
        if (addr == AW'(A_MODE1)) rd_mux = mode1_q;
        if (addr == AW'(A_MODE2)) rd_mux = mode2_q;
        if (addr == AW'(A_GSEL))  rd_mux = gsel_q;
    end

    // Register read data for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mode0_q == MODE0_RST && mode1_q == MODE1_RST &&
                           mode2_q == MODE2_RST && latch_q == '0 && gsel_q == '0));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr) == AW'(A_DATA)) |-> rdata == $past(pin_level));

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(addr) > AW'(A_GSEL)) |-> rdata == '0);

endmodule

// File: rtl/pinmode_lane.sv
// Module: decode of one pin's drive mode into pad controls and bus routing.
// Purely combinational; assumes pin_sync is the synchronized pad level.
module pinmode_lane
    import pinmode_pkg::*;
(
    input  logic [2:0] mode_code,
    input  logic       latch_bit,
    input  logic       gsel_bit,
    input  logic       gbus_out_bit,
    input  logic       pin_sync,
    output pad_ctl_t   ctl,
    output logic       read_bit,
    output logic       gbus_in_bit
);

    drv_mode_e mode;
    logic      hiz;
    logic      out_val;

    // Classify the mode and pick the output value source.
    always_comb begin
        mode    = drv_mode_e'(mode_code);
        hiz     = (mode == MODE_HIZ_DIG) || (mode == MODE_HIZ_ANA);
        out_val = (gsel_bit && !hiz) ? gbus_out_bit : latch_bit;
    end

    // Translate mode and value into drive, pull and buffer enables.
    always_comb begin
        ctl       = '0;
        ctl.in_en = (mode != MODE_HIZ_ANA);
        case (mode)
            MODE_PULL_DN: begin
                ctl.drv_hi  = out_val;
                ctl.pull_dn = !out_val;
            end
            MODE_STRONG: begin
                ctl.drv_hi = out_val;
                ctl.drv_lo = !out_val;
            end
            MODE_PULL_UP: begin
                ctl.pull_up = out_val;
                ctl.drv_lo  = !out_val;
            end
            MODE_OD_HI: ctl.drv_hi = out_val;
            MODE_SLOW: begin
                ctl.drv_hi = out_val;
                ctl.drv_lo = !out_val;
                ctl.slow   = 1'b1;
            end
            MODE_OD_LO: ctl.drv_lo = !out_val;
            default: ;
        endcase
    end

    // Gate the sampled pin by the input buffer for reads and global input.
    always_comb begin
        read_bit    = pin_sync & ctl.in_en;
        gbus_in_bit = gsel_bit & hiz & read_bit;
    end

endmodule

// File: rtl/pinmode_port.sv
// Module: top of the configurable drive-mode I/O port.
// Connects register file, input synchronizer and one decode lane per pin.
// Assumes a synchronous active-low reset and a single clock domain for the bus.
module pinmode_port
    import pinmode_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int AW          = ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_drv_hi,
    output logic [W-1:0]  pad_drv_lo,
    output logic [W-1:0]  pad_pull_up,
    output logic [W-1:0]  pad_pull_dn,
    output logic [W-1:0]  pad_in_en,
    output logic [W-1:0]  pad_slow,
    input  logic [W-1:0]  gbus_out,
    output logic [W-1:0]  gbus_in
);

    logic [W-1:0] latch_q, mode0_q, mode1_q, mode2_q, gsel_q;
    logic [W-1:0] pin_sync, pin_level;

    pinmode_regs #(.W(W), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .pin_level (pin_level),
        .rdata     (reg_rdata),
        .latch_q   (latch_q),
        .mode0_q   (mode0_q),
        .mode1_q   (mode1_q),
        .mode2_q   (mode2_q),
        .gsel_q    (gsel_q)
    );

    pinmode_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar n = 0; n < W; n++) begin : g_lane
        pad_ctl_t ctl;

        pinmode_lane lane_i (
            .mode_code    ({mode2_q[n], mode1_q[n], mode0_q[n]}),
            .latch_bit    (latch_q[n]),
            .gsel_bit     (gsel_q[n]),
            .gbus_out_bit (gbus_out[n]),
            .pin_sync     (pin_sync[n]),
            .ctl          (ctl),
            .read_bit     (pin_level[n]),
            .gbus_in_bit  (gbus_in[n])
        );

        assign pad_drv_hi[n]  = ctl.drv_hi;
        assign pad_drv_lo[n]  = ctl.drv_lo;
        assign pad_pull_up[n] = ctl.pull_up;
        assign pad_pull_dn[n] = ctl.pull_dn;
        assign pad_in_en[n]   = ctl.in_en;
        assign pad_slow[n]    = ctl.slow;
    end

    // Masks of pins by mode, derived straight from the register bits for checks.
    logic [W-1:0] hiz_mask, strong_mask;
    assign hiz_mask    = mode1_q & ~mode0_q;
    assign strong_mask = mode0_q & ~mode1_q & ~mode2_q;

    p_no_fight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drv_hi & pad_drv_lo) == '0);

    p_hiz_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_drv_hi | pad_drv_lo | pad_pull_up | pad_pull_dn) & hiz_mask) == '0);

    p_gbus_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((gsel_q & strong_mask) & (pad_drv_hi ^ gbus_out)) == '0);

    p_gbus_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gbus_in & ~gsel_q) == '0);

    p_reset_pads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_in_en == '0 && pad_drv_hi == '0 && pad_drv_lo == '0));

endmodule

// File: tb/pinmode_port_tb_top.sv
// Bench: table of mode/value vectors walked by one loop, then directed tests.
module pinmode_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_drv_hi, pad_drv_lo, pad_pull_up, pad_pull_dn, pad_in_en, pad_slow;
    logic [7:0] gbus_out = '0;
    logic [7:0] gbus_in;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pinmode_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_in_en(pad_in_en), .pad_slow(pad_slow),
        .gbus_out(gbus_out), .gbus_in(gbus_in)
    );

    // Expected pad controls indexed by {code, value}:
    // bits {slow, in_en, pull_dn, pull_up, drv_lo, drv_hi}.
    localparam logic [5:0] EXP_TAB [16] = '{
        6'b011000, 6'b010001,   // 000 pull-down   (R5)
        6'b010010, 6'b010001,   // 001 strong      (R3)
        6'b010000, 6'b010000,   // 010 high-Z dig  (R6)
        6'b010010, 6'b010100,   // 011 pull-up     (R5)
        6'b010000, 6'b010001,   // 100 drive-high  (R4)
        6'b110010, 6'b110001,   // 101 slow strong (R3)
        6'b000000, 6'b000000,   // 110 high-Z ana  (R6)
        6'b010010, 6'b010000    // 111 drive-low   (R4)
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode_all(input logic [2:0] m);
        wr(3'd1, {8{m[0]}});
        wr(3'd2, {8{m[1]}});
        wr(3'd3, {8{m[2]}});
    endtask

    task automatic chk_pads(input string tag, input logic [7:0] e [6]);
        chk({tag, " drv_hi"},  pad_drv_hi,  e[0]);
        chk({tag, " drv_lo"},  pad_drv_lo,  e[1]);
        chk({tag, " pull_up"}, pad_pull_up, e[2]);
        chk({tag, " pull_dn"}, pad_pull_dn, e[3]);
        chk({tag, " in_en"},   pad_in_en,   e[4]);
        chk({tag, " slow"},    pad_slow,    e[5]);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] e [6];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and in readback.
        for (int f = 0; f < 6; f++) e[f] = 8'h00;
        chk_pads("R1 reset", e);
        rd(3'd1, r); chk("R1 mode0 reset", r, 8'h00);
        rd(3'd2, r); chk("R1 mode1 reset", r, 8'hFF);
        rd(3'd3, r); chk("R1 mode2 reset", r, 8'hFF);
        rd(3'd4, r); chk("R1 gsel reset", r, 8'h00);

        // R3 R4 R5 R6: every code with both values on all pins.
        for (int i = 0; i < 16; i++) begin
            logic [2:0] m;
            m = 3'(i >> 1);
            set_mode_all(m);
            wr(3'd0, {8{i[0]}});
            for (int f = 0; f < 6; f++) e[f] = {8{EXP_TAB[i][f]}};
            chk_pads($sformatf("R3/R4/R5/R6 code %0d val %0d", m, i[0]), e);
        end

        // R2: pin n holds code n, pins 0-3 output 1, pins 4-7 output 0.
        wr(3'd1, 8'hAA); wr(3'd2, 8'hCC); wr(3'd3, 8'hF0); wr(3'd0, 8'h0F);
        for (int f = 0; f < 6; f++) e[f] = 8'h00;
        for (int n = 0; n < 8; n++) begin
            logic [5:0] t;
            t = EXP_TAB[n * 2 + ((n < 4) ? 1 : 0)];
            for (int f = 0; f < 6; f++) e[f][n] = t[f];
        end
        chk_pads("R2 per-pin codes", e);

        // R6: high-Z digital ignores latch, pins readable.
        set_mode_all(3'b010);
        wr(3'd0, 8'hFF);
        pad_in = 8'h5A; settle();
        chk("R6 hiz dig drv_hi", pad_drv_hi, 8'h00);
        chk("R6 hiz dig pull_dn", pad_pull_dn, 8'h00);
        rd(3'd0, r); chk("R6 hiz dig read", r, 8'h5A);
        wr(3'd0, 8'h00);
        chk("R6 hiz dig drv_lo after write", pad_drv_lo, 8'h00);
        // R6: high-Z analog reads zero.
        set_mode_all(3'b110); settle();
        rd(3'd0, r); chk("R6 hiz ana read", r, 8'h00);

        // R7: pin0 strong output, pin1 pull-down input pressed high.
        wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd0, 8'h00);
        pad_in = 8'h02; settle();
        rd(3'd0, r); chk("R7 read returns pins", r, 8'h02);
        wr(3'd0, r | 8'h01);
        chk("R7 rmw locks pulled input high", pad_drv_hi, 8'h03);
        chk("R7 rmw pull_dn released", pad_pull_dn, 8'hFC);
        pad_in = 8'h00; settle();
        rd(3'd0, r); chk("R7 read not latch", r, 8'h00);

        // R8: latency of a pin change through sync and read register.
        set_mode_all(3'b010);
        pad_in = 8'h00; settle();
        rd(3'd0, r);
        pad_in = 8'hC3;                 // change at this negedge, address held at 0
        @(negedge clk); chk("R8 edge1 old", reg_rdata, 8'h00);
        @(negedge clk); chk("R8 edge2 old", reg_rdata, 8'h00);
        @(negedge clk); chk("R8 edge3 new", reg_rdata, 8'hC3);

        // R9: global output bus replaces latch in strong mode.
        set_mode_all(3'b001);
        wr(3'd0, 8'h00);
        gbus_out = 8'hC3;
        wr(3'd4, 8'hFF);
        chk("R9 gbus drv_hi", pad_drv_hi, 8'hC3);
        chk("R9 gbus drv_lo", pad_drv_lo, 8'h3C);
        chk("R10 gbus_in off when driving", gbus_in, 8'h00);
        wr(3'd4, 8'h0F);
        chk("R9 partial select drv_hi", pad_drv_hi, 8'h03);

        // R10: high-Z digital feeds global input bus where selected.
        set_mode_all(3'b010);
        pad_in = 8'hFF; settle();
        chk("R10 gbus_in hiz dig", gbus_in, 8'h0F);
        chk("R10 hiz ignores gbus_out", pad_drv_hi, 8'h00);
        set_mode_all(3'b110); settle();
        chk("R10 gbus_in hiz ana", gbus_in, 8'h00);

        // R11: readback and unmapped addresses.
        wr(3'd1, 8'h5A); wr(3'd2, 8'hA5); wr(3'd3, 8'h3C); wr(3'd4, 8'h81);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd1, r); chk("R11 mode0 readback", r, 8'h5A);
        rd(3'd2, r); chk("R11 mode1 readback", r, 8'hA5);
        rd(3'd3, r); chk("R11 mode2 readback", r, 8'h3C);
        rd(3'd4, r); chk("R11 gsel readback", r, 8'h81);
        rd(3'd5, r); chk("R11 unmapped 5", r, 8'h00);
        rd(3'd7, r); chk("R11 unmapped 7", r, 8'h00);

        // R1: reset again after activity restores defaults.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 re-reset in_en", pad_in_en, 8'h00);
        rd(3'd4, r); chk("R1 re-reset gsel", r, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule